// File: doc/BRIEF.md
# Dual-Bus Transfer Retry Controller

This controller runs one bus transfer over a pair of redundant buses. It accepts a request that carries a starting bus, a retry policy and a retry count. It launches attempts toward a message engine and tells the engine which bus each attempt uses. After each attempt the engine reports that it is done, and whether it failed. When an attempt fails and attempts are still left, the controller picks the bus for the next attempt according to the policy.

The controller stops on the first successful attempt, or after the last allowed attempt. It then reports the outcome, the bus of the final attempt and the total number of attempts made. There are three policies:
- stay on the starting bus;
- swap buses on every retry;
- use up the retry count on the starting bus, then the same count on the other bus.

Top module: `dbr_retry_ctrl`

## Requirements
- R1: After a synchronous reset, `att_strobe`, `fin_valid` and `busy` are 0.
- R2: A request accepted while idle produces a one-cycle `att_strobe` in the cycle after `req_valid` is sampled. Its `att_bus` equals `req_bus`, where 0 is bus A and 1 is bus B.
- R3: In policy code 0, every attempt uses the starting bus. Policy code 3 behaves exactly like code 0.
- R4: In policy code 1, the bus of each retry is the opposite of the bus of the attempt before it.
- R5: Policy code 2 works in two phases. The first attempt and N retries use the starting bus. The next N retries use the other bus.
- R6: With effective retry count N, a transfer that keeps failing makes N+1 attempts in codes 0, 1 and 3, and 2N+1 attempts in code 2. It then reports failure, and no further strobe follows. With N = 0 exactly one attempt is made.
- R7: An attempt that completes without error ends the transfer at once. The report then has `fin_ok` = 1 and gives the number of attempts made so far.
- R8: `fin_valid` pulses for one cycle in the cycle after the final `eng_done`. `busy` is 0 in that cycle. `fin_bus` gives the bus of the final attempt, and `fin_attempts` gives the total number of attempts.
- R9: A `req_valid` that arrives while a transfer is in progress has no effect on that transfer. An `eng_done` that arrives while idle has no effect.
- R10: A retry count above MAX_RETRY (6) is treated as MAX_RETRY.
- R11: `att_strobe` is never high in two consecutive cycles. An `eng_done` that arrives in the same cycle as the strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, accepted only when idle |
| req_bus | input | 1 | Starting bus: 0 = A, 1 = B |
| req_mode | input | 2 | Retry policy: 0 same, 1 swap, 2 two-phase, 3 as 0 |
| req_retries | input | 3 | Retry count, clamped to MAX_RETRY |
| eng_done | input | 1 | Engine finished the current attempt |
| eng_err | input | 1 | The finished attempt failed (valid with eng_done) |
| busy | output | 1 | A transfer is in progress |
| att_strobe | output | 1 | One-cycle pulse that launches an attempt |
| att_bus | output | 1 | Bus for the launched attempt |
| fin_valid | output | 1 | One-cycle pulse with the final report |
| fin_ok | output | 1 | The final attempt succeeded |
| fin_bus | output | 1 | Bus of the final attempt |
| fin_attempts | output | 4 | Total attempts made |

## Verification
Every result is registered.

- The first strobe is due one cycle after the request is sampled.
- Each later strobe, or the final report, is due one cycle after the `eng_done` that triggers it.

The bench drives all inputs on the falling edge and samples on the next falling edge, exactly one rising edge later. It holds `eng_done` back by one idle cycle after each strobe, and checks that the strobe has dropped in that cycle. The sweep covers every policy code, retry counts 0 to 7, both starting buses, and every position of the first success, including no success at all.

// File: rtl/dbr_pkg.sv
`timescale 1ns/1ps
package dbr_pkg;
  typedef enum logic [1:0] {
    RM_SAME  = 2'd0,
    RM_SWAP  = 2'd1,
    RM_SPLIT = 2'd2,
    RM_RSVD  = 2'd3
  } retry_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } ctrl_state_e;
endpackage

// File: rtl/dbr_req_norm.sv
`timescale 1ns/1ps
module dbr_req_norm #(
  parameter int MAX_RETRY = 6,
  parameter int RETRY_W   = 3
) (
  input  logic [1:0]         mode_in,
  input  logic [RETRY_W-1:0] retries_in,
  output dbr_pkg::retry_mode_e mode_out,
  output logic [RETRY_W-1:0] retries_out
);
  import dbr_pkg::*;
  localparam logic [RETRY_W-1:0] CAP = RETRY_W'(MAX_RETRY);

  always_comb begin
    mode_out = retry_mode_e'(mode_in);
    if (mode_out == RM_RSVD) mode_out = RM_SAME;
    retries_out = (retries_in > CAP) ? CAP : retries_in;
  end
endmodule

// File: rtl/dbr_bus_policy.sv
`timescale 1ns/1ps
module dbr_bus_policy #(
  parameter int RETRY_W = 3,
  parameter int ATT_W   = 4
) (
  input  dbr_pkg::retry_mode_e mode,
  input  logic [RETRY_W-1:0]   retries,
  input  logic                 first_bus,
  input  logic [ATT_W-1:0]     idx,
  output logic                 bus,
  output logic [ATT_W-1:0]     total
);
  import dbr_pkg::*;
  logic [ATT_W-1:0] n_ext;

  always_comb begin
    n_ext = ATT_W'(retries);
    unique case (mode)
      RM_SWAP:  begin bus = first_bus ^ idx[0];                     total = n_ext + 1'b1; end
      RM_SPLIT: begin bus = (idx > n_ext) ? ~first_bus : first_bus; total = (n_ext << 1) + 1'b1; end
      default:  begin bus = first_bus;                              total = n_ext + 1'b1; end
    endcase
  end
endmodule

// File: rtl/dbr_retry_ctrl.sv
`timescale 1ns/1ps
module dbr_retry_ctrl #(
  parameter int MAX_RETRY = 6,
  parameter int RETRY_W   = 3,
  parameter int ATT_W     = $clog2(2*MAX_RETRY+2)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_bus,
  input  logic [1:0]         req_mode,
  input  logic [RETRY_W-1:0] req_retries,
  input  logic               eng_done,
  input  logic               eng_err,
  output logic               busy,
  output logic               att_strobe,
  output logic               att_bus,
  output logic               fin_valid,
  output logic               fin_ok,
  output logic               fin_bus,
  output logic [ATT_W-1:0]   fin_attempts
);
  import dbr_pkg::*;

  ctrl_state_e        state;
  retry_mode_e        mode_q, mode_n;
  logic [RETRY_W-1:0] n_q, n_n;
  logic               first_q;
  logic [ATT_W-1:0]   att_cnt;
  logic               nxt_bus;
  logic [ATT_W-1:0]   total_w;
  logic               attempt_end;

  dbr_req_norm #(.MAX_RETRY(MAX_RETRY), .RETRY_W(RETRY_W)) u_norm (
    .mode_in(req_mode), .retries_in(req_retries),
    .mode_out(mode_n), .retries_out(n_n)
  );

  dbr_bus_policy #(.RETRY_W(RETRY_W), .ATT_W(ATT_W)) u_policy (
    .mode(mode_q), .retries(n_q), .first_bus(first_q), .idx(att_cnt),
    .bus(nxt_bus), .total(total_w)
  );

  // done is only taken once the strobe cycle has passed
  assign attempt_end = (state == ST_WAIT) && eng_done && !att_strobe;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      mode_q       <= RM_SAME;
      n_q          <= '0;
      first_q      <= 1'b0;
      att_cnt      <= '0;
      busy         <= 1'b0;
      att_strobe   <= 1'b0;
      att_bus      <= 1'b0;
      fin_valid    <= 1'b0;
      fin_ok       <= 1'b0;
      fin_bus      <= 1'b0;
      fin_attempts <= '0;
    end else begin
      att_strobe <= 1'b0;
      fin_valid  <= 1'b0;
      if (state == ST_IDLE) begin
        if (req_valid) begin
          mode_q     <= mode_n;
          n_q        <= n_n;
          first_q    <= req_bus;
          att_bus    <= req_bus;
          att_strobe <= 1'b1;
          att_cnt    <= ATT_W'(1);
          busy       <= 1'b1;
          state      <= ST_WAIT;
        end
      end else if (attempt_end) begin
        if (!eng_err || att_cnt >= total_w) begin
          fin_valid    <= 1'b1;
          fin_ok       <= !eng_err;
          fin_bus      <= att_bus;
          fin_attempts <= att_cnt;
          busy         <= 1'b0;
          state        <= ST_IDLE;
        end else begin
          att_bus    <= nxt_bus;
          att_strobe <= 1'b1;
          att_cnt    <= att_cnt + 1'b1;
        end
      end
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!att_strobe && !fin_valid && !busy));

  // R11
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    att_strobe |=> !att_strobe);

  // R3
  same_bus_chk: assert property (@(posedge clk) disable iff (rst)
    (att_strobe && att_cnt > ATT_W'(1) && mode_q == RM_SAME) |-> $stable(att_bus));

  // R4
  swap_bus_chk: assert property (@(posedge clk) disable iff (rst)
    (att_strobe && att_cnt > ATT_W'(1) && mode_q == RM_SWAP) |-> (att_bus != $past(att_bus)));

  // R5
  split_phase_chk: assert property (@(posedge clk) disable iff (rst)
    (att_strobe && mode_q == RM_SPLIT && att_cnt > (ATT_W'(n_q) + 1'b1)) |-> (att_bus != first_q));

  // R6
  attempts_bound_chk: assert property (@(posedge clk) disable iff (rst)
    fin_valid |-> (fin_attempts >= ATT_W'(1) && fin_attempts <= ATT_W'(2*MAX_RETRY+1)));

  // R8
  fin_idle_chk: assert property (@(posedge clk) disable iff (rst)
    fin_valid |-> (!busy && !att_strobe));
endmodule

// File: tb/dbr_retry_ctrl_bench.sv
`timescale 1ns/1ps
module dbr_retry_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic       req_valid, req_bus, eng_done, eng_err;
  logic [1:0] req_mode;
  logic [2:0] req_retries;
  logic       busy, att_strobe, att_bus, fin_valid, fin_ok, fin_bus;
  logic [3:0] fin_attempts;

  int  checks = 0;
  int  failures = 0;
  bit  ended = 1'b0;

  always #10 clk = ~clk;

  dbr_retry_ctrl u_dbr_retry_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_bus(req_bus),
    .req_mode(req_mode), .req_retries(req_retries), .eng_done(eng_done),
    .eng_err(eng_err), .busy(busy), .att_strobe(att_strobe), .att_bus(att_bus),
    .fin_valid(fin_valid), .fin_ok(fin_ok), .fin_bus(fin_bus),
    .fin_attempts(fin_attempts)
  );

  task automatic chk(input bit cond, input string tag, input int act, input int exp);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_bus(input int m, input int n, input int first, input int i);
    case (m)
      1:       return first ^ (i % 2);
      2:       return (i > n) ? 1 - first : first;
      default: return first;
    endcase
  endfunction

  function automatic string bus_tag(input int m);
    case (m)
      1:       return "R4 swap bus";
      2:       return "R5 two-phase bus";
      default: return "R3 same bus";
    endcase
  endfunction

  task automatic run(input int m, input int n, input int b, input int s);
    int ne, tot, exp_att;
    bit ok;
    ne = (n > 6) ? 6 : n;
    tot = (m == 2) ? 2*ne + 1 : ne + 1;
    ok = (s <= tot);
    exp_att = ok ? s : tot;
    // R9: a done pulse while idle must be ignored
    eng_done = 1'b1; eng_err = 1'b0;
    @(negedge clk);
    eng_done = 1'b0;
    chk(!fin_valid && !att_strobe, "R9 idle done", int'(fin_valid), 0);
    req_valid = 1'b1; req_bus = b[0]; req_mode = m[1:0]; req_retries = n[2:0];
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < exp_att; k++) begin
      chk(att_strobe, (k == 0) ? "R2 first strobe" : "R6 retry strobe", int'(att_strobe), 1);
      chk(int'(att_bus) == exp_bus(m, ne, b, k), bus_tag(m), int'(att_bus), exp_bus(m, ne, b, k));
      chk(busy, "R8 busy during transfer", int'(busy), 1);
      @(negedge clk);
      chk(!att_strobe, "R11 single strobe", int'(att_strobe), 0);
      if (k == 0) begin
        // R9: a new request in flight must not disturb the transfer
        req_valid = 1'b1; req_bus = ~b[0]; req_mode = m[1:0] ^ 2'd1; req_retries = 3'd0;
      end
      eng_done = 1'b1;
      eng_err = (k + 1 != s);
      @(negedge clk);
      eng_done = 1'b0; eng_err = 1'b0; req_valid = 1'b0;
    end
    chk(fin_valid, "R8 report pulse", int'(fin_valid), 1);
    chk(!att_strobe, "R6 no strobe after end", int'(att_strobe), 0);
    chk(fin_ok == ok, "R7 outcome", int'(fin_ok), int'(ok));
    chk(int'(fin_attempts) == exp_att, (n > 6) ? "R10 clamped count" : "R6 attempt count",
        int'(fin_attempts), exp_att);
    chk(int'(fin_bus) == exp_bus(m, ne, b, exp_att - 1), "R8 final bus",
        int'(fin_bus), exp_bus(m, ne, b, exp_att - 1));
    chk(!busy, "R8 idle at report", int'(busy), 0);
    @(negedge clk);
    chk(!fin_valid, "R8 report one cycle", int'(fin_valid), 0);
  endtask

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_bus = 1'b0; req_mode = 2'd0;
    req_retries = 3'd0; eng_done = 1'b0; eng_err = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!att_strobe && !fin_valid && !busy, "R1 reset state", int'(busy), 0);
    for (int m = 0; m < 4; m++)
      for (int n = 0; n < 8; n++)
        for (int b = 0; b < 2; b++) begin
          int ne, tot;
          ne = (n > 6) ? 6 : n;
          tot = (m == 2) ? 2*ne + 1 : ne + 1;
          for (int s = 1; s <= tot + 1; s++) run(m, n, b, s);
        end
    if (!ended) begin
      ended = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule